// File: doc/BRIEF.md
# Delayed Read Completion Responder

This block sits on the requesting side of a bridge and answers the repeated read that a master issues after its first attempt was deferred. It holds one pending read entry: address, command and a prefetchable flag. When the master comes back with a request, the block compares it against that entry. It then either tells the master to retry or starts handing over words from the read-data FIFO that the far side is filling.

When the entry is prefetchable and the far-side read has not finished, the block can start streaming anyway (flow-through). It disconnects the master with data when the buffer runs dry, so the master can come back later at the next address. Any transfer ends with a disconnect on the last word, at an aligned 4 KB page edge, or when the master stops early. In the last two cases the leftover buffered data is thrown away. A one-cycle completion pulse follows each release of the entry.

Top module: `drd_responder`

## Requirements
- R1: After reset the block holds no entry: `entry_busy`, `tgt_sel`, `tgt_rdy`, `tgt_disc`, `tgt_retry`, `entry_done`, `fifo_pop` and `fifo_flush` are all 0, and a request made in that state is answered with retry.
- R2: A request is answered, one cycle after `req_valid`, with `tgt_retry`=1 and no service if any of the following holds: the full 32-bit address differs from the entry, the commands differ, `order_ok`=0, `fifo_empty`=1, or the far-side read is still running (`far_done`=0) on a non-prefetchable entry.
- R3: Command codes are memory read 4'h6, read line 4'hE and read multiple 4'hC. With `alias_en`=1 all three are treated as 4'h6 on both the request and the entry side. With `alias_en`=0 a request matches only the identical code.
- R4: An accepted request raises `tgt_sel` one cycle after `req_valid`. While selected, each cycle with `ini_rdy`=1, `ini_end`=0 and a non-empty FIFO shows `tgt_rdy`=1, `tgt_data`=`fifo_data` and `fifo_pop`=1 in that same cycle, and the stored address advances by 4.
- R5: When the word taken is the only one left (`fifo_one`) and the far side has finished, `tgt_disc`=1 accompanies it, `entry_done` pulses the next cycle, and `entry_busy` and `tgt_sel` drop.
- R6: `ini_end` while selected pulses `fifo_flush` in the same cycle, pulses `entry_done` the next cycle and releases the entry.
- R7: A prefetchable entry is accepted while `far_done`=0 (flow-through). If its single remaining word is taken while the far side is still active, that word carries `tgt_disc`=1, the entry is kept, with no `entry_done`, at the advanced address, and a later request at that address is accepted.
- R8: A word taken from address bits [11:2] all ones (the last dword of an aligned 4 KB page) carries `tgt_disc`=1 and `fifo_flush`=1, and `entry_done` follows, unless R5 already ends the transfer.
- R9: If `fifo_full` is seen while selected in flow-through, the far read counts as finished. The final buffered word then ends the entry as in R5 rather than stalling as in R7.
- R10: `ent_load` is ignored while an entry is held. A request at the ignored address is retried and the original entry is still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_load | input | 1 | Capture a pending read entry |
| ent_addr | input | 32 | Entry address |
| ent_cmd | input | 4 | Entry command |
| ent_pref | input | 1 | Entry is prefetchable |
| far_done | input | 1 | Far-side read has finished |
| order_ok | input | 1 | Posted-write ordering satisfied |
| alias_en | input | 1 | Alias read line/multiple to memory read |
| req_valid | input | 1 | Master presents a request this cycle |
| req_addr | input | 32 | Request address |
| req_cmd | input | 4 | Request command |
| ini_rdy | input | 1 | Master ready for a data word |
| ini_end | input | 1 | Master terminates the transfer |
| fifo_data | input | 32 | Head word of the read-data FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_one | input | 1 | FIFO holds exactly one word |
| fifo_full | input | 1 | FIFO is full |
| fifo_pop | output | 1 | Take the head word |
| fifo_flush | output | 1 | Discard all buffered words |
| tgt_data | output | 32 | Data to the master |
| tgt_rdy | output | 1 | Data word valid this cycle |
| tgt_disc | output | 1 | Disconnect together with this word |
| tgt_retry | output | 1 | Request answered with retry |
| tgt_sel | output | 1 | Request accepted and being served |
| entry_busy | output | 1 | An entry is held |
| entry_done | output | 1 | Entry released (one-cycle pulse) |

## Verification
A wrong match or service decision shows on `tgt_retry` or `tgt_sel` exactly one cycle after the request. A broken address tracker or mode flag first shows on `tgt_disc` at the word where the disconnect should or should not fall, which can be several words into a burst. The page-edge and stall sweeps therefore place that word at each position in turn. A lost release leaves `entry_busy` high, and the next request or load exposes it within a few cycles.

// File: rtl/drd_responder.sv
module drd_responder #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ent_load,
  input  logic [AW-1:0] ent_addr,
  input  logic [3:0]    ent_cmd,
  input  logic          ent_pref,
  input  logic          far_done,
  input  logic          order_ok,
  input  logic          alias_en,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_cmd,
  input  logic          ini_rdy,
  input  logic          ini_end,
  input  logic [DW-1:0] fifo_data,
  input  logic          fifo_empty,
  input  logic          fifo_one,
  input  logic          fifo_full,
  output logic          fifo_pop,
  output logic          fifo_flush,
  output logic [DW-1:0] tgt_data,
  output logic          tgt_rdy,
  output logic          tgt_disc,
  output logic          tgt_retry,
  output logic          tgt_sel,
  output logic          entry_busy,
  output logic          entry_done
);
  localparam logic [3:0] CMD_RD   = 4'h6;
  localparam logic [3:0] CMD_LINE = 4'hE;
  localparam logic [3:0] CMD_MULT = 4'hC;
  localparam logic [AW-1:0] STEP  = AW'(4);

  function automatic logic [3:0] norm(input logic [3:0] c, input logic al);
    return (al && (c == CMD_LINE || c == CMD_MULT)) ? CMD_RD : c;
  endfunction

  logic          held, serving, full_seen, retry_q, done_q, pref_q;
  logic [AW-1:0] cur_addr;
  logic [3:0]    cmd_q;

  logic match, serve_ok, xfer, flow, page_end, last_fin, stall, bnd, term, release_e;

  assign match    = held && !serving && req_addr == cur_addr &&
                    norm(req_cmd, alias_en) == norm(cmd_q, alias_en);
  assign serve_ok = match && order_ok && !fifo_empty && (far_done || pref_q);
  assign xfer     = serving && ini_rdy && !ini_end && !fifo_empty;
  assign flow     = !far_done && !full_seen;
  assign page_end = &cur_addr[PAGE_BITS-1:2];
  assign last_fin = xfer && fifo_one && !flow;
  assign stall    = xfer && fifo_one && flow && !page_end;
  assign bnd      = xfer && page_end && !last_fin;
  assign term     = serving && ini_end;
  assign release_e = last_fin || bnd || term;

  assign fifo_pop   = xfer;
  assign fifo_flush = bnd || term;
  assign tgt_rdy    = xfer;
  assign tgt_data   = xfer ? fifo_data : '0;
  assign tgt_disc   = last_fin || stall || bnd;
  assign tgt_retry  = retry_q;
  assign tgt_sel    = serving;
  assign entry_busy = held;
  assign entry_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      serving   <= 1'b0;
      full_seen <= 1'b0;
      retry_q   <= 1'b0;
      done_q    <= 1'b0;
      pref_q    <= 1'b0;
      cur_addr  <= '0;
      cmd_q     <= '0;
    end else begin
      retry_q <= req_valid && !serving && !serve_ok;
      done_q  <= release_e;
      if (ent_load && !held) begin
        held     <= 1'b1;
        cur_addr <= ent_addr;
        cmd_q    <= ent_cmd;
        pref_q   <= ent_pref;
      end
      if (req_valid && serve_ok) begin
        serving   <= 1'b1;
        full_seen <= 1'b0;
      end
      if (serving && fifo_full && !far_done) full_seen <= 1'b1;
      if (xfer) cur_addr <= cur_addr + STEP;
      if (stall) serving <= 1'b0;
      if (release_e) begin
        held    <= 1'b0;
        serving <= 1'b0;
      end
    end
  end
endmodule

module drd_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic fifo_flush,
  input logic tgt_rdy,
  input logic tgt_disc,
  input logic tgt_retry,
  input logic tgt_sel,
  input logic entry_busy,
  input logic entry_done
);
  AST_RDY_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rdy |-> !fifo_empty); // R4
  AST_DISC_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_disc |-> (tgt_rdy && fifo_pop)); // R5
  AST_FLUSH_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> entry_done); // R6
  AST_NO_RETRY_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel |-> !tgt_retry); // R2
  AST_DONE_FREES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> (!entry_busy && !tgt_sel)); // R5
  AST_SEL_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel |-> entry_busy); // R7
endmodule

bind drd_responder drd_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
  .fifo_flush(fifo_flush), .tgt_rdy(tgt_rdy), .tgt_disc(tgt_disc),
  .tgt_retry(tgt_retry), .tgt_sel(tgt_sel), .entry_busy(entry_busy),
  .entry_done(entry_done));

// File: tb/drd_responder_test.sv
module drd_responder_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic ent_load = 0, ent_pref = 0, far_done = 0, order_ok = 1, alias_en = 0;
  logic [31:0] ent_addr = 0, req_addr = 0;
  logic [3:0] ent_cmd = 0, req_cmd = 0;
  logic req_valid = 0, ini_rdy = 0, ini_end = 0;
  logic [31:0] fifo_data, tgt_data;
  logic fifo_empty, fifo_one, fifo_full, fifo_pop, fifo_flush;
  logic tgt_rdy, tgt_disc, tgt_retry, tgt_sel, entry_busy, entry_done;

  int total = 0, bad = 0;
  logic finished = 0;

  logic [31:0] q [DEPTH];
  logic [2:0] rp = 0, wp = 0;
  logic [3:0] cnt = 0;
  logic push = 0;
  logic [31:0] push_val = 0;

  assign fifo_data  = q[rp];
  assign fifo_empty = cnt == 0;
  assign fifo_one   = cnt == 1;
  assign fifo_full  = cnt == DEPTH;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (fifo_flush) begin
      cnt <= 0; rp <= 0; wp <= 0;
    end else begin
      if (push) begin q[wp] <= push_val; wp <= wp + 1; end
      if (fifo_pop) rp <= rp + 1;
      cnt <= cnt + (push ? 4'd1 : 4'd0) - (fifo_pop ? 4'd1 : 4'd0);
    end
  end

  drd_responder uut (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] a, input logic [3:0] c, input logic p);
    @(negedge clk); ent_load = 1; ent_addr = a; ent_cmd = c; ent_pref = p;
    @(negedge clk); ent_load = 0;
  endtask

  task automatic fill(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); push = 1; push_val = base + i;
    end
    @(negedge clk); push = 0;
  endtask

  task automatic request(input logic [31:0] a, input logic [3:0] c, output logic rt, output logic sl);
    @(negedge clk); req_valid = 1; req_addr = a; req_cmd = c;
    @(negedge clk); req_valid = 0; #1; rt = tgt_retry; sl = tgt_sel;
  endtask

  task automatic take(input logic [31:0] expd, input logic expdisc, input string tag);
    @(negedge clk); ini_rdy = 1; #1;
    chk(tgt_rdy === 1'b1 && tgt_data === expd, {tag, " data"}, tgt_data, expd);
    chk(tgt_disc === expdisc, {tag, " disc"}, {31'd0, tgt_disc}, {31'd0, expdisc});
  endtask

  task automatic after_end(input logic expdone, input logic expbusy, input string tag);
    @(negedge clk); ini_rdy = 0; ini_end = 0; #1;
    chk(entry_done === expdone, {tag, " done"}, {31'd0, entry_done}, {31'd0, expdone});
    chk(entry_busy === expbusy, {tag, " busy"}, {31'd0, entry_busy}, {31'd0, expbusy});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic rt, sl;
    repeat (3) @(negedge clk);
    #1;
    chk(!entry_busy && !tgt_sel && !tgt_rdy && !tgt_disc && !tgt_retry && !entry_done && !fifo_pop && !fifo_flush,
        "R1 reset outputs", {26'd0, entry_busy, tgt_sel, tgt_rdy, tgt_disc, tgt_retry, entry_done}, 0);
    rst_n = 1;
    request(32'h100, 4'h6, rt, sl);
    chk(rt && !sl, "R1 no entry retry", {30'd0, rt, sl}, 2);

    // R4 R5: plain transfers of 1..6 words
    far_done = 1;
    for (int n = 1; n <= 6; n++) begin
      load(32'h1000_0040 + 32'(n) * 64, 4'h6, 0);
      fill(n, 32'hA000 + 32'(n) * 16);
      request(32'h1000_0040 + 32'(n) * 64, 4'h6, rt, sl);
      chk(!rt && sl, "R4 accept", {30'd0, rt, sl}, 1);
      for (int i = 0; i < n; i++) take(32'hA000 + 32'(n) * 16 + 32'(i), i == n - 1, "R4 R5 burst");
      after_end(1, 0, "R5 release");
    end

    // R3 alias sweep
    for (int al = 0; al < 2; al++)
      for (int s = 0; s < 3; s++)
        for (int r = 0; r < 3; r++) begin
          logic [3:0] sc, rc;
          logic expm;
          sc = (s == 0) ? 4'h6 : (s == 1) ? 4'hE : 4'hC;
          rc = (r == 0) ? 4'h6 : (r == 1) ? 4'hE : 4'hC;
          expm = (s == r) || (al == 1);
          alias_en = al[0];
          load(32'h2000_0000, sc, 0);
          fill(1, 32'h55);
          request(32'h2000_0000, rc, rt, sl);
          chk(sl == expm && rt == !expm, "R3 alias match", {30'd0, rt, sl}, {30'd0, !expm, expm});
          if (!sl) begin
            request(32'h2000_0000, sc, rt, sl);
            chk(sl, "R3 exact match", {31'd0, sl}, 1);
          end
          take(32'h55, 1, "R3 word");
          after_end(1, 0, "R3 release");
        end
    alias_en = 0;

    // R2 retry causes
    load(32'h3000_0000, 4'h6, 0);
    request(32'h3000_0000, 4'h6, rt, sl);
    chk(rt && !sl, "R2 empty fifo", {30'd0, rt, sl}, 2);
    fill(2, 32'h77);
    request(32'h3000_0004, 4'h6, rt, sl);
    chk(rt && !sl, "R2 addr mismatch", {30'd0, rt, sl}, 2);
    request(32'h3000_0000, 4'h7, rt, sl);
    chk(rt && !sl, "R2 cmd mismatch", {30'd0, rt, sl}, 2);
    order_ok = 0;
    request(32'h3000_0000, 4'h6, rt, sl);
    chk(rt && !sl, "R2 ordering", {30'd0, rt, sl}, 2);
    order_ok = 1; far_done = 0;
    request(32'h3000_0000, 4'h6, rt, sl);
    chk(rt && !sl, "R2 nonpref far busy", {30'd0, rt, sl}, 2);
    far_done = 1;
    // R10 load ignored while held
    load(32'h3100_0000, 4'h6, 0);
    request(32'h3100_0000, 4'h6, rt, sl);
    chk(rt && !sl, "R10 load ignored", {30'd0, rt, sl}, 2);
    request(32'h3000_0000, 4'h6, rt, sl);
    chk(!rt && sl, "R10 original kept", {30'd0, rt, sl}, 1);
    // R6 early termination
    take(32'h77, 0, "R6 first");
    @(negedge clk); ini_rdy = 0; ini_end = 1; #1;
    chk(fifo_flush === 1'b1 && !tgt_rdy, "R6 flush", {31'd0, fifo_flush}, 1);
    after_end(1, 0, "R6 release");
    #1; chk(fifo_empty === 1'b1, "R6 discarded", {28'd0, cnt}, 0);

    // R7 flow-through stall then resume
    far_done = 0;
    load(32'h4000_0100, 4'hE, 1);
    fill(2, 32'hB0);
    request(32'h4000_0100, 4'hE, rt, sl);
    chk(!rt && sl, "R7 flow accept", {30'd0, rt, sl}, 1);
    take(32'hB0, 0, "R7 w0");
    take(32'hB1, 1, "R7 stall");
    after_end(0, 1, "R7 kept");
    #1; chk(!tgt_sel, "R7 deselected", {31'd0, tgt_sel}, 0);
    fill(1, 32'hB2);
    request(32'h4000_0104, 4'hE, rt, sl);
    chk(rt && !sl, "R7 old addr retried", {30'd0, rt, sl}, 2);
    request(32'h4000_0108, 4'hE, rt, sl);
    chk(!rt && sl, "R7 resume", {30'd0, rt, sl}, 1);
    far_done = 1;
    take(32'hB2, 1, "R7 final");
    after_end(1, 0, "R7 release");

    // R9 full buffer ends flow-through
    far_done = 0;
    load(32'h5000_0000, 4'h6, 1);
    fill(DEPTH, 32'hC0);
    request(32'h5000_0000, 4'h6, rt, sl);
    chk(!rt && sl, "R9 accept", {30'd0, rt, sl}, 1);
    for (int i = 0; i < DEPTH; i++) take(32'hC0 + 32'(i), i == DEPTH - 1, "R9 burst");
    after_end(1, 0, "R9 release");

    // R8 page edge at each position
    for (int k = 1; k <= 4; k++) begin
      load(32'h6000_1000 - 32'(k) * 4, 4'h6, 1);
      fill(6, 32'hD0);
      request(32'h6000_1000 - 32'(k) * 4, 4'h6, rt, sl);
      chk(!rt && sl, "R8 accept", {30'd0, rt, sl}, 1);
      for (int i = 0; i < k; i++) begin
        take(32'hD0 + 32'(i), i == k - 1, "R8 edge");
        if (i == k - 1) chk(fifo_flush === 1'b1, "R8 flush", {31'd0, fifo_flush}, 1);
      end
      after_end(1, 0, "R8 release");
      #1; chk(fifo_empty === 1'b1, "R8 discarded", {28'd0, cnt}, 0);
    end
    far_done = 1;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule